// File: doc/BRIEF.md
# Asynchronous Memory Bus Cycle Timer

This block generates the strobe sequence for one area of asynchronous SRAM or flash that is selected by chip select. A requester presents a read or a write with an address, write data and a target space number. The block then drives an active-low chip select, read strobe and write enable, and holds address and write data stable for the whole access. Each access passes through four phases. An optional idle gap keeps chip select high. A setup phase asserts chip select before the strobe. A strobe phase lasts for the programmed wait states. A hold phase keeps chip select low after the strobe negates. One cycle after the hold phase ends, the block raises a done pulse, and for a read it returns the captured data with that pulse.

The clock of the block is the half-cycle timing tick, so one bus cycle is two clocks. All timing comes from two registers per space. The bus-control register holds five idle-gap fields. The wait-control register holds the read wait, the write wait, the setup and the hold. Both registers are loaded through a plain one-cycle write port. Wait and gap counts use non-linear codes, and one write-wait code means "use the read wait". The idle gap that is inserted depends on whether the previous access was a read or a write, on whether it was in the same space as the new one, and on the previous space's bus-control register.

Requests use a valid/ready handshake. A request transfers on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the timer is idle, so a requester that holds `req_valid` simply waits. The request fields must stay stable until the transfer. The response is a single-cycle `rsp_valid` pulse with no back-pressure.

Top module: `async_bus_timer`

## Requirements
- R1: During reset and right after it, `mem_cs_n`, `mem_rd_n` and `mem_we_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: The setup code S (wait-control bits [8:7]) places the strobe 2*S+1 clocks after `mem_cs_n` falls. During those clocks both strobes are high.
- R3: The read-wait code (wait-control bits [3:0]) maps codes 0..7 to 0,1,2,3,4,5,6,8 wait cycles and codes 8..12 to 10,12,14,18,24 wait cycles. Codes 13..15 also give 24. A read keeps `mem_rd_n` low for 2*(wait+1) clocks.
- R4: The write-wait code (wait-control bits [6:4]) gives the read wait when it is 0, and code-1 wait cycles when it is 1..7. A write keeps `mem_we_n` low for 2*(wait+1) clocks.
- R5: The hold code H (wait-control bits [10:9]) keeps `mem_cs_n` low for 2*H+1 clocks after the strobe negates.
- R6: The gap codes 0..7 mean 0,1,2,4,6,8,10,12 cycles. Before the next chip select, `mem_cs_n` stays high for at least max(2, 2*gap) clocks. It stays high for exactly that number when the next request is already waiting.
- R7: The gap field is taken from the previous access's space register. Bus-control bits [14:12] apply after a write. Bits [8:6] apply to a read followed by a write in the same space, and bits [11:9] to one in a different space. Bits [2:0] apply to a read followed by a read in the same space, and bits [5:3] to one in a different space. The first access after reset has no gap.
- R8: Read data is sampled from `mem_rdata` on the last clock of the read strobe. `rsp_valid` is high for one clock, in the first clock that `mem_cs_n` is high again, and `rsp_rdata` holds the read data during that clock.
- R9: After reset, every gap field of every space is 2 cycles, setup and hold are code 0, read wait is code 2 and write wait is code 0.
- R10: While an access is in progress `req_ready` is low. A write drives `req_addr` and `req_wdata` on `mem_addr` and `mem_wdata` with `mem_wdata_oe` high while `mem_we_n` is low. `mem_rd_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle timing tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one timing register this clock |
| cfg_wcr | input | 1 | 1 selects wait-control, 0 selects bus-control |
| cfg_sel | input | 2 | Space whose register is written |
| cfg_wdata | input | 15 | Register value (wait-control uses bits [10:0]) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Timer idle, request can transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_space | input | 2 | Target space number |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Done pulse |
| rsp_rdata | output | 16 | Data of the last read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 20 | Address to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_wdata_oe | output | 1 | Write data output enable |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The assertions check ordering on every cycle. A strobe is only ever low inside chip select, and it is never low on the clock that chip select falls or on the clock it negates. The two strobes never overlap. Ready is never high while chip select is low. The done pulse lasts one clock and sits on the clock where chip select is released, and every chip select is preceded by at least the gap latched for that access. The exact lengths of the setup, strobe, hold and gap phases can only be shown by the bench's scenarios, which compare them with the code tables and the previous-access selection rule. The same applies to the reset register values and to data capture during the strobe.

// File: rtl/abt_pkg.sv
package abt_pkg;

  localparam int BCR_W     = 15;
  localparam int WCR_W     = 11;
  localparam int MAX_TICKS = 2 * 24 + 2;
  localparam int TCW       = $clog2(MAX_TICKS + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_e;

  // bus-control: idle-gap codes
  typedef struct packed {
    logic [2:0] after_wr;
    logic [2:0] rw_diff;
    logic [2:0] rw_same;
    logic [2:0] rr_diff;
    logic [2:0] rr_same;
  } bcr_t;

  // wait-control: phase lengths
  typedef struct packed {
    logic [1:0] hold;
    logic [1:0] setup;
    logic [2:0] wr_wait;
    logic [3:0] rd_wait;
  } wcr_t;

  localparam bcr_t BCR_RST = '{3'd2, 3'd2, 3'd2, 3'd2, 3'd2};
  localparam wcr_t WCR_RST = '{2'd0, 2'd0, 3'd0, 4'd2};

  function automatic logic [4:0] rd_wait_cycles(input logic [3:0] code);
    logic [4:0] r;
    case (code)
      4'd7:    r = 5'd8;
      4'd8:    r = 5'd10;
      4'd9:    r = 5'd12;
      4'd10:   r = 5'd14;
      4'd11:   r = 5'd18;
      4'd12, 4'd13, 4'd14, 4'd15: r = 5'd24;
      default: r = {1'b0, code};
    endcase
    return r;
  endfunction

  function automatic logic [4:0] wr_wait_cycles(input logic [2:0] wcode,
                                                input logic [3:0] rcode);
    logic [4:0] r;
    if (wcode == 3'd0) r = rd_wait_cycles(rcode);
    else               r = {2'b00, wcode - 3'd1};
    return r;
  endfunction

  function automatic logic [3:0] gap_cycles(input logic [2:0] code);
    logic [3:0] r;
    if (code <= 3'd2) r = {1'b0, code};
    else              r = {code, 1'b0} - 4'd2;
    return r;
  endfunction

endpackage

// File: rtl/abt_cfg_regs.sv
module abt_cfg_regs
  import abt_pkg::*;
#(
  parameter int NSPACE = 4,
  localparam int SPW = $clog2(NSPACE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_wcr,
  input  logic [SPW-1:0]   cfg_sel,
  input  logic [BCR_W-1:0] cfg_wdata,
  output bcr_t             bcr_o [NSPACE],
  output wcr_t             wcr_o [NSPACE]
);

  for (genvar s = 0; s < NSPACE; s++) begin : g_space
    logic hit;
    assign hit = cfg_we && (cfg_sel == SPW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bcr_o[s] <= BCR_RST;
        wcr_o[s] <= WCR_RST;
      end else if (hit) begin
        if (cfg_wcr) wcr_o[s] <= wcr_t'(cfg_wdata[WCR_W-1:0]);
        else         bcr_o[s] <= bcr_t'(cfg_wdata);
      end
    end
  end

endmodule

// File: rtl/abt_gap_sel.sv
module abt_gap_sel
  import abt_pkg::*;
#(
  parameter int NSPACE = 4,
  localparam int SPW = $clog2(NSPACE)
) (
  input  logic           prev_valid,
  input  logic           prev_write,
  input  logic [SPW-1:0] prev_space,
  input  bcr_t           prev_bcr,
  input  logic           next_write,
  input  logic [SPW-1:0] next_space,
  output logic [TCW-1:0] gap_ticks
);

  logic       same;
  logic [2:0] code;

  always_comb begin
    same = (prev_space == next_space);
    if (prev_write)      code = prev_bcr.after_wr;
    else if (next_write) code = same ? prev_bcr.rw_same : prev_bcr.rw_diff;
    else                 code = same ? prev_bcr.rr_same : prev_bcr.rr_diff;
    gap_ticks = prev_valid ? TCW'({gap_cycles(code), 1'b0}) : '0;
  end

endmodule

// File: rtl/abt_seq.sv
module abt_seq
  import abt_pkg::*;
#(
  parameter int NSPACE = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int SPW = $clog2(NSPACE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [SPW-1:0] req_space,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  wcr_t           req_wcr,
  input  logic [TCW-1:0] gap_ticks,
  output logic           prev_valid,
  output logic           prev_write,
  output logic [SPW-1:0] prev_space,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           mem_cs_n,
  output logic           mem_rd_n,
  output logic           mem_we_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_wdata_oe,
  input  logic [DW-1:0]  mem_rdata
);

  phase_e         state;
  logic [TCW-1:0] cnt, low_run, gap_q, su_q, str_q, ho_q;
  logic           wr_q;
  logic [SPW-1:0] space_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q, rdata_q;

  logic           accept, cs_on, gap_met;
  logic [TCW:0]   low_next;
  logic [4:0]     acc_wait;
  logic [TCW-1:0] acc_su, acc_str, acc_ho, gap_need;

  always_comb begin
    accept   = (state == PH_IDLE) && req_valid;
    cs_on    = (state == PH_SETUP) || (state == PH_STROBE) || (state == PH_HOLD);
    low_next = {1'b0, low_run} + (TCW+1)'(1);
    gap_need = (state == PH_IDLE) ? gap_ticks : gap_q;
    gap_met  = low_next >= {1'b0, gap_need};
    acc_wait = req_write ? wr_wait_cycles(req_wcr.wr_wait, req_wcr.rd_wait)
                         : rd_wait_cycles(req_wcr.rd_wait);
    acc_su   = TCW'({req_wcr.setup, 1'b1});
    acc_ho   = TCW'({req_wcr.hold, 1'b1});
    acc_str  = TCW'({acc_wait, 1'b0}) + TCW'(2);
  end

  // consecutive clocks with chip select released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= '1;
    else if (cs_on)            low_run <= '0;
    else if (low_run != '1)    low_run <= low_run + TCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      gap_q      <= '0;
      su_q       <= '0;
      str_q      <= '0;
      ho_q       <= '0;
      wr_q       <= 1'b0;
      space_q    <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      prev_valid <= 1'b0;
      prev_write <= 1'b0;
      prev_space <= '0;
    end else begin
      case (state)
        PH_IDLE: if (accept) begin
          wr_q    <= req_write;
          space_q <= req_space;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          su_q    <= acc_su;
          str_q   <= acc_str;
          ho_q    <= acc_ho;
          gap_q   <= gap_ticks;
          if (gap_met) begin
            state <= PH_SETUP;
            cnt   <= acc_su - TCW'(1);
          end else begin
            state <= PH_GAP;
          end
        end
        PH_GAP: if (gap_met) begin
          state <= PH_SETUP;
          cnt   <= su_q - TCW'(1);
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            state <= PH_STROBE;
            cnt   <= str_q - TCW'(1);
          end else begin
            cnt <= cnt - TCW'(1);
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            if (!wr_q) rdata_q <= mem_rdata;
            state <= PH_HOLD;
            cnt   <= ho_q - TCW'(1);
          end else begin
            cnt <= cnt - TCW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            state      <= PH_DONE;
            prev_valid <= 1'b1;
            prev_write <= wr_q;
            prev_space <= space_q;
          end else begin
            cnt <= cnt - TCW'(1);
          end
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == PH_IDLE);
  assign rsp_valid    = (state == PH_DONE);
  assign rsp_rdata    = rdata_q;
  assign mem_cs_n     = !cs_on;
  assign mem_rd_n     = !((state == PH_STROBE) && !wr_q);
  assign mem_we_n     = !((state == PH_STROBE) && wr_q);
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign mem_wdata_oe = cs_on && wr_q;

  // R1: idle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_cs_n && mem_rd_n && mem_we_n && req_ready && !rsp_valid));

  // R2: strobe only inside chip select, never on its first clock
  p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_we_n) |-> !mem_cs_n);
  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (mem_rd_n && mem_we_n));

  // R5: chip select outlasts the strobe
  p_hold_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_rd_n) || $rose(mem_we_n)) |-> !mem_cs_n);

  // R6: every chip select follows at least the latched idle gap
  p_gap_respected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (low_run >= gap_q));

  // R8: done is one clock, exactly where chip select is released
  p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> rsp_valid);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: no ready while busy, never both strobes
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !rsp_valid));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_we_n));

endmodule

// File: rtl/async_bus_timer.sv
module async_bus_timer
  import abt_pkg::*;
#(
  parameter int NSPACE = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int SPW = $clog2(NSPACE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_wcr,
  input  logic [SPW-1:0]   cfg_sel,
  input  logic [BCR_W-1:0] cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [SPW-1:0]   req_space,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_cs_n,
  output logic             mem_rd_n,
  output logic             mem_we_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_wdata_oe,
  input  logic [DW-1:0]    mem_rdata
);

  bcr_t           bcr [NSPACE];
  wcr_t           wcr [NSPACE];
  logic           prev_valid, prev_write;
  logic [SPW-1:0] prev_space;
  logic [TCW-1:0] gap_ticks;

  abt_cfg_regs #(.NSPACE(NSPACE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wcr(cfg_wcr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bcr_o(bcr), .wcr_o(wcr)
  );

  abt_gap_sel #(.NSPACE(NSPACE)) u_gap (
    .prev_valid(prev_valid), .prev_write(prev_write), .prev_space(prev_space),
    .prev_bcr(bcr[prev_space]), .next_write(req_write), .next_space(req_space),
    .gap_ticks(gap_ticks)
  );

  abt_seq #(.NSPACE(NSPACE), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wcr(wcr[req_space]), .gap_ticks(gap_ticks),
    .prev_valid(prev_valid), .prev_write(prev_write), .prev_space(prev_space),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata)
  );

endmodule

// File: tb/async_bus_timer_test.sv
`timescale 1ns/1ps
module async_bus_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_wcr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [14:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_space = '0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_cs_n, mem_rd_n, mem_we_n, mem_wdata_oe;
  logic [15:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_fn(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A3};
  endfunction
  assign mem_rdata = !mem_rd_n ? mem_fn(mem_addr) : 16'hDEAD;

  async_bus_timer uut (.*);

  // shadow timing registers
  logic [14:0] sh_bcr [4];
  logic [10:0] sh_wcr [4];
  bit  have_prev = 0, prev_wr = 0;
  int  prev_sp = 0;

  function automatic int f_rd(input logic [3:0] c);
    case (c)
      7: return 8;  8: return 10; 9: return 12; 10: return 14; 11: return 18;
      12, 13, 14, 15: return 24;
      default: return int'(c);
    endcase
  endfunction
  function automatic int f_gap(input logic [2:0] c);
    case (c)
      0: return 0; 1: return 1; 2: return 2; 3: return 4;
      4: return 6; 5: return 8; 6: return 10; default: return 12;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor, sampled away from the active edge
  int  cyc = 0, lowcnt = 1000, su = 0, st = 0, ho = 0;
  int  m_su, m_st, m_ho, m_low, t_done;
  bit  m_done, prev_cs = 1;
  logic [19:0] m_wa;
  logic [15:0] m_wd;
  bit  m_oe;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      lowcnt = 1000; su = 0; st = 0; ho = 0; prev_cs = 1;
    end else begin
      if (mem_cs_n) begin
        if (!prev_cs) begin
          m_su = su; m_st = st; m_ho = ho; m_done = rsp_valid; t_done = cyc; lowcnt = 1;
        end else lowcnt++;
      end else begin
        if (prev_cs) begin m_low = lowcnt; su = 0; st = 0; ho = 0; end
        if (!mem_rd_n || !mem_we_n) begin
          st++;
          if (!mem_we_n) begin m_wa = mem_addr; m_wd = mem_wdata; m_oe = mem_wdata_oe; end
        end else if (st == 0) su++;
        else ho++;
      end
      prev_cs = mem_cs_n;
    end
  end

  task automatic cfg_write(input bit is_wcr, input int sp, input logic [14:0] v);
    @(negedge clk); #1;
    cfg_we = 1; cfg_wcr = is_wcr; cfg_sel = 2'(sp); cfg_wdata = v;
    @(negedge clk); #1;
    cfg_we = 0;
    if (is_wcr) sh_wcr[sp] = v[10:0]; else sh_bcr[sp] = v;
  endtask

  task automatic access(input bit wr, input int sp, input logic [19:0] a,
                        input logic [15:0] d, input int k);
    int t_drive, base, g, code_w, wt, exp_low;
    logic [14:0] b;
    logic [10:0] w;
    repeat (k) @(negedge clk);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_valid = 1; req_write = wr; req_space = 2'(sp); req_addr = a; req_wdata = d;
    t_drive = cyc;
    @(negedge clk); #1;
    req_valid = 0;
    chk(req_ready == 0, "R10 ready low while busy", int'(req_ready), 0);
    do begin @(negedge clk); #1; end while (!rsp_valid);
    w = sh_wcr[sp];
    chk(m_su == 2*int'(w[8:7]) + 1, "R2 setup clocks", m_su, 2*int'(w[8:7]) + 1);
    code_w = int'(w[6:4]);
    wt = (!wr || code_w == 0) ? f_rd(w[3:0]) : code_w - 1;
    chk(m_st == 2*(wt+1), wr ? "R4 write strobe clocks" : "R3 read strobe clocks",
        m_st, 2*(wt+1));
    chk(m_ho == 2*int'(w[10:9]) + 1, "R5 hold clocks", m_ho, 2*int'(w[10:9]) + 1);
    chk(m_done == 1 && t_done == cyc, "R8 done on release", t_done, cyc);
    if (have_prev) begin
      b = sh_bcr[prev_sp];
      if (prev_wr)      g = f_gap(b[14:12]);
      else if (wr)      g = f_gap(prev_sp == sp ? b[8:6] : b[11:9]);
      else              g = f_gap(prev_sp == sp ? b[2:0] : b[5:3]);
      base = t_drive - t_prev_done + 1;
      exp_low = (2*g > base) ? 2*g : base;
      chk(m_low == exp_low, "R6 R7 idle gap clocks", m_low, exp_low);
    end
    if (wr) begin
      chk(m_wa == a && m_wd == d && m_oe, "R10 write address/data", int'(m_wd), int'(d));
    end else begin
      chk(rsp_rdata == mem_fn(a), "R8 read data", int'(rsp_rdata), int'(mem_fn(a)));
    end
    @(negedge clk); #1;
    chk(rsp_valid == 0, "R8 done single clock", int'(rsp_valid), 0);
    t_prev_done = t_done;
    have_prev = 1; prev_wr = wr; prev_sp = sp;
  endtask
  int t_prev_done = 0;

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 4; s++) begin
      sh_bcr[s] = 15'b010_010_010_010_010;
      sh_wcr[s] = 11'b00_00_000_0010;
    end
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_rd_n && mem_we_n, "R1 strobes high in reset", int'(mem_cs_n), 1);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready == 1 && rsp_valid == 0, "R1 ready after reset", int'(req_ready), 1);
    chk(mem_cs_n && mem_rd_n && mem_we_n, "R1 strobes high after reset", int'(mem_cs_n), 1);

    // R9: reset timing values, read then same-space write back to back
    access(0, 0, 20'h01234, 16'h0, 0);
    access(1, 0, 20'h00042, 16'hBEEF, 0);
    access(0, 1, 20'h0ABCD, 16'h0, 0);

    // R3: codes 12 and 13 both give 24 wait cycles
    cfg_write(1, 1, 15'(11'b00_00_000_1101));
    access(0, 1, 20'h11111, 16'h0, 0);
    cfg_write(1, 1, 15'(11'b01_10_000_1100));
    access(0, 1, 20'h22222, 16'h0, 0);
    // R4: write wait code 1 gives zero waits, code 0 follows read wait
    cfg_write(1, 2, 15'(11'b11_01_001_1011));
    access(1, 2, 20'h33333, 16'h1357, 0);
    cfg_write(1, 2, 15'(11'b00_00_000_1001));
    access(1, 2, 20'h44444, 16'h2468, 0);
    // R7: distinct gap codes in space 3 select by order and space
    cfg_write(0, 3, 15'b111_001_011_101_000);
    access(0, 3, 20'h50000, 16'h0, 0);
    access(0, 3, 20'h50001, 16'h0, 0);
    access(0, 3, 20'h50002, 16'h0, 0);
    access(0, 0, 20'h50003, 16'h0, 0);
    access(0, 3, 20'h50004, 16'h0, 0);
    access(1, 3, 20'h50005, 16'hAAAA, 0);
    access(1, 3, 20'h50006, 16'h5555, 3);
    access(0, 3, 20'h50007, 16'h0, 0);
    access(1, 1, 20'h50008, 16'h0F0F, 0);

    // constrained random traffic
    for (int i = 0; i < 200; i++) begin
      if (i % 16 == 0) begin
        cfg_write(1, int'($urandom_range(3)), 15'($urandom));
        cfg_write(0, int'($urandom_range(3)), 15'($urandom));
      end
      access(1'($urandom_range(1)), int'($urandom_range(3)), 20'($urandom),
             16'($urandom), int'($urandom_range(3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule